// File: doc/BRIEF.md
# Multi-hart debug run control

This block is the run-control core of a debug controller that looks after a small group of harts. A debugger writes a control word. The word carries a hart index, a halt request, a resume request, set and clear controls for halt-on-reset, a reset acknowledge and a module-active bit. The block keeps these per-hart bits:

- the halt request,
- the resume request,
- the resume acknowledge,
- halt-on-reset,
- a sticky have-reset flag.

It drives a halt-request line and a resume-request line to each hart. Each hart reports back whether it is halted, running or unavailable, and pulses a reset-complete line when a reset of that hart finishes.

The hart index is a live input. The status outputs always describe the hart it points at. That hart is in exactly one of four states: nonexistent, unavailable, halted or running. Each state has an all-selected flag and an any-selected flag, and the have-reset and resume-acknowledge bits have the same pair. The module-active bit resets everything else in the block while it is low. It stays writable during that time and reads back one cycle after a write.

Top module: `hart_runctl`

## Requirements
- R1: A control write sets the selected hart's halt-request bit to the value of its halt field. 1 sets the bit and 0 clears it. The bit drives that hart's halt-request output in the cycle after the write. Other harts' bits are unchanged.
- R2: If a hart pulses reset-complete while its halt-on-reset bit is set, its halt-request output rises in the next cycle. It stays high until that hart reports halted.
- R3: A write with resume set and halt clear, aimed at a hart that reports halted, raises that hart's resume-request output and clears its resume acknowledge, both in the next cycle. The resume is ignored if the hart is not halted, or if the same write also sets halt.
- R4: While a resume request is pending and the hart reports running, the next cycle drops the request and sets the resume acknowledge. A pending request and a set acknowledge never coexist.
- R5: The have-reset bit of a hart sets on every reset-complete pulse. A write with acknowledge-reset clears it, but only for the selected hart. A pulse in the same cycle as the acknowledge wins, and the bit stays set.
- R6: A write with set-halt-on-reset sets the selected hart's halt-on-reset bit, and a write with clear-halt-on-reset clears it. If both are set in one write, clear wins.
- R7: The state of the selected hart is decided in this order: nonexistent, then unavailable (unavailable input high), then halted (halted input high), then running. Exactly one of the four any-flags is high. For a single selected hart each all-flag equals its any-flag. The have-reset and resume-acknowledge flags report that hart's bits.
- R8: The hart index is 20 bits wide. An index at or above the number of harts reports nonexistent, with all other flags low, and a write to it changes no hart.
- R9: Module-active resets to 0 and reads back the written value one cycle after each write. While it reads 0, every per-hart bit returns to its reset value, request outputs are low, reset-complete pulses are not recorded, and the other fields of a write are ignored.
- R10: After power-up reset, each hart's resume acknowledge is 1. Its halt request, resume request, halt-on-reset and have-reset bits are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_hartsel_i | input | 20 | Selected hart index (live) |
| ctl_halt_i | input | 1 | Halt field of the control word |
| ctl_resume_i | input | 1 | Resume field |
| ctl_set_hor_i | input | 1 | Set halt-on-reset field |
| ctl_clr_hor_i | input | 1 | Clear halt-on-reset field |
| ctl_ack_reset_i | input | 1 | Acknowledge have-reset field |
| ctl_active_i | input | 1 | Module-active field |
| active_o | output | 1 | Module-active readback |
| hart_halted_i | input | NUM_HARTS | Per-hart halted indication |
| hart_running_i | input | NUM_HARTS | Per-hart running indication |
| hart_reset_done_i | input | NUM_HARTS | Per-hart one-cycle reset-complete pulse |
| hart_unavail_i | input | NUM_HARTS | Per-hart unavailable indication |
| halt_req_o | output | NUM_HARTS | Per-hart halt request |
| resume_req_o | output | NUM_HARTS | Per-hart resume request |
| sts_all_halted_o | output | 1 | All selected harts halted |
| sts_any_halted_o | output | 1 | Any selected hart halted |
| sts_all_running_o | output | 1 | All selected harts running |
| sts_any_running_o | output | 1 | Any selected hart running |
| sts_all_unavail_o | output | 1 | All selected harts unavailable |
| sts_any_unavail_o | output | 1 | Any selected hart unavailable |
| sts_all_nonexist_o | output | 1 | All selected harts nonexistent |
| sts_any_nonexist_o | output | 1 | Any selected hart nonexistent |
| sts_all_havereset_o | output | 1 | All selected harts have have-reset set |
| sts_any_havereset_o | output | 1 | Any selected hart has have-reset set |
| sts_all_resumeack_o | output | 1 | All selected harts have resume acknowledge set |
| sts_any_resumeack_o | output | 1 | Any selected hart has resume acknowledge set |

## Verification
The bench targets these collisions and what a faulty design would show:

- A reset pulse in the same cycle as an acknowledge: a design with the wrong priority loses a reset.
- A halt and a resume in one write: a design that honours both sends a running request to a hart that is also asked to halt.
- A resume aimed at a running hart: a design that does not check clears the acknowledge and then waits forever for it.
- Set and clear of halt-on-reset together: a design with the wrong priority arms a halt the debugger meant to drop.
- A reset pulse after halt-on-reset was cleared: a design that still halts the hart here is caught.

The bench also covers indices past the last hart, which a design with a truncated compare would alias onto a real hart. It writes with module-active low and fields set, where a design that leaks the fields keeps a stale halt request alive after reactivation.

// File: rtl/rc_pkg.sv
// Shared types for the multi-hart run-control block.
// Assumes: one state slot per hart, and a control word of plain one-bit fields.
package rc_pkg;

    // Width of the hart index field of the control word
    localparam int HSEL_W = 20;

    // Per-hart stored state
    typedef struct packed {
        logic halt_req;
        logic resume_req;
        logic resume_ack;
        logic halt_on_reset;
        logic have_reset;
        logic reset_halt_pend;
    } slot_state_t;

    // Control word fields as seen by one hart slot
    typedef struct packed {
        logic wr_sel;
        logic halt;
        logic resume;
        logic set_hor;
        logic clr_hor;
        logic ack_reset;
    } slot_cmd_t;

    // Value a slot takes at power-up and while the module is inactive
    localparam slot_state_t SLOT_RESET = '{
        halt_req:        1'b0,
        resume_req:      1'b0,
        resume_ack:      1'b1,
        halt_on_reset:   1'b0,
        have_reset:      1'b0,
        reset_halt_pend: 1'b0
    };

endpackage

// File: rtl/rc_sel_decode.sv
// Hart index decoder.
// Turns the wide hart index into a one-hot mask over the implemented harts,
// plus a flag telling whether the index names an implemented hart.
// Assumes: NUM_HARTS fits in SEL_W bits.
module rc_sel_decode #(
    parameter int NUM_HARTS = 4,
    parameter int SEL_W     = 20
) (
    input  logic [SEL_W-1:0]     sel_i,
    output logic [NUM_HARTS-1:0] mask_o,
    output logic                 in_range_o
);

    localparam logic [SEL_W-1:0] LIMIT = SEL_W'(NUM_HARTS);

    // One compare per implemented hart
    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_dec
        assign mask_o[g] = (sel_i == SEL_W'(g));
    end

    // Index range test for the nonexistent state
    assign in_range_o = (sel_i < LIMIT);

endmodule

// File: rtl/rc_hart_slot.sv
// State slot for one hart.
// Holds the halt request, resume request and acknowledge, halt-on-reset,
// have-reset and the pending halt after a reset. Drives that hart's request lines.
// Assumes: cmd_i.wr_sel is high only in the cycle of a write that selects this hart;
// hart_reset_done_i is a one-cycle pulse.
module rc_hart_slot
    import rc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active_i,
    input  slot_cmd_t cmd_i,
    input  logic      hart_halted_i,
    input  logic      hart_running_i,
    input  logic      hart_reset_done_i,
    output logic      halt_req_o,
    output logic      resume_req_o,
    output logic      resume_ack_o,
    output logic      have_reset_o
);

    slot_state_t st_q;
    slot_state_t st_d;

    // Next-state rules for every field of the slot
    always_comb begin
        st_d = st_q;
        if (cmd_i.wr_sel) begin
            st_d.halt_req = cmd_i.halt;
        end
        if (st_q.resume_req && hart_running_i) begin
            st_d.resume_req = 1'b0;
            st_d.resume_ack = 1'b1;
        end
        if (cmd_i.wr_sel && cmd_i.resume && !cmd_i.halt && hart_halted_i) begin
            st_d.resume_req = 1'b1;
            st_d.resume_ack = 1'b0;
        end
        if (cmd_i.wr_sel && cmd_i.clr_hor) begin
            st_d.halt_on_reset = 1'b0;
        end else if (cmd_i.wr_sel && cmd_i.set_hor) begin
            st_d.halt_on_reset = 1'b1;
        end
        if (hart_reset_done_i) begin
            st_d.have_reset = 1'b1;
        end else if (cmd_i.wr_sel && cmd_i.ack_reset) begin
            st_d.have_reset = 1'b0;
        end
        if (hart_reset_done_i && st_q.halt_on_reset) begin
            st_d.reset_halt_pend = 1'b1;
        end else if (hart_halted_i) begin
            st_d.reset_halt_pend = 1'b0;
        end
    end

    // Slot register, cleared at power-up and while the module is inactive
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            st_q <= SLOT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    // Request lines are gated so they drop in the first inactive cycle
    assign halt_req_o   = active_i & (st_q.halt_req | st_q.reset_halt_pend);
    assign resume_req_o = active_i & st_q.resume_req;
    assign resume_ack_o = st_q.resume_ack;
    assign have_reset_o = st_q.have_reset;

    // R5
    have_reset_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && hart_reset_done_i) |=> have_reset_o);

    // R2
    hor_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && hart_reset_done_i && st_q.halt_on_reset) |=> (halt_req_o || !active_i));

    // R3
    resume_only_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.resume_req) |-> $past(hart_halted_i));

    // R4
    ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.resume_req |-> !st_q.resume_ack);

    // R9
    inactive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (!st_q.have_reset && st_q.resume_ack && !st_q.halt_on_reset
                       && !st_q.halt_req && !st_q.resume_req));

endmodule

// File: rtl/rc_status.sv
// Status summaries over the selected harts.
// Classifies each hart as unavailable, halted or running, and reduces each state,
// have-reset and resume acknowledge to all/any flags over the selection mask.
// Assumes: the mask is empty exactly when the index is out of range.
module rc_status #(
    parameter int NUM_HARTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_HARTS-1:0] sel_mask_i,
    input  logic                 in_range_i,
    input  logic [NUM_HARTS-1:0] halted_i,
    input  logic [NUM_HARTS-1:0] unavail_i,
    input  logic [NUM_HARTS-1:0] have_reset_i,
    input  logic [NUM_HARTS-1:0] resume_ack_i,
    output logic                 all_halted_o,
    output logic                 any_halted_o,
    output logic                 all_running_o,
    output logic                 any_running_o,
    output logic                 all_unavail_o,
    output logic                 any_unavail_o,
    output logic                 all_nonexist_o,
    output logic                 any_nonexist_o,
    output logic                 all_havereset_o,
    output logic                 any_havereset_o,
    output logic                 all_resumeack_o,
    output logic                 any_resumeack_o
);

    logic [NUM_HARTS-1:0] st_halted;
    logic [NUM_HARTS-1:0] st_running;
    logic [NUM_HARTS-1:0] st_unavail;
    logic                 some_sel;

    // Per-hart state classification, unavailable before halted before running
    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_cls
        assign st_unavail[g] = unavail_i[g];
        assign st_halted[g]  = ~unavail_i[g] & halted_i[g];
        assign st_running[g] = ~unavail_i[g] & ~halted_i[g];
    end

    assign some_sel = |sel_mask_i;

    // All-flags need at least one selected hart; any-flags are masked ORs
    assign all_halted_o    = some_sel & (&(st_halted    | ~sel_mask_i));
    assign any_halted_o    = |(st_halted    & sel_mask_i);
    assign all_running_o   = some_sel & (&(st_running   | ~sel_mask_i));
    assign any_running_o   = |(st_running   & sel_mask_i);
    assign all_unavail_o   = some_sel & (&(st_unavail   | ~sel_mask_i));
    assign any_unavail_o   = |(st_unavail   & sel_mask_i);
    assign all_havereset_o = some_sel & (&(have_reset_i | ~sel_mask_i));
    assign any_havereset_o = |(have_reset_i & sel_mask_i);
    assign all_resumeack_o = some_sel & (&(resume_ack_i | ~sel_mask_i));
    assign any_resumeack_o = |(resume_ack_i & sel_mask_i);
    assign all_nonexist_o  = ~in_range_i;
    assign any_nonexist_o  = ~in_range_i;

    // R7
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({any_halted_o, any_running_o, any_unavail_o, any_nonexist_o}) == 1);

endmodule

// File: rtl/hart_runctl.sv
// Multi-hart debug run control, top level.
// Holds the module-active bit, decodes the hart index, routes control writes to
// one state slot per hart and builds the status summaries.
// Assumes: a single hart index selects at most one hart; hart inputs are synchronous to clk.
module hart_runctl #(
    parameter int NUM_HARTS = 4,
    parameter int SEL_W     = rc_pkg::HSEL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr_i,
    input  logic [SEL_W-1:0]     ctl_hartsel_i,
    input  logic                 ctl_halt_i,
    input  logic                 ctl_resume_i,
    input  logic                 ctl_set_hor_i,
    input  logic                 ctl_clr_hor_i,
    input  logic                 ctl_ack_reset_i,
    input  logic                 ctl_active_i,
    output logic                 active_o,
    input  logic [NUM_HARTS-1:0] hart_halted_i,
    input  logic [NUM_HARTS-1:0] hart_running_i,
    input  logic [NUM_HARTS-1:0] hart_reset_done_i,
    input  logic [NUM_HARTS-1:0] hart_unavail_i,
    output logic [NUM_HARTS-1:0] halt_req_o,
    output logic [NUM_HARTS-1:0] resume_req_o,
    output logic                 sts_all_halted_o,
    output logic                 sts_any_halted_o,
    output logic                 sts_all_running_o,
    output logic                 sts_any_running_o,
    output logic                 sts_all_unavail_o,
    output logic                 sts_any_unavail_o,
    output logic                 sts_all_nonexist_o,
    output logic                 sts_any_nonexist_o,
    output logic                 sts_all_havereset_o,
    output logic                 sts_any_havereset_o,
    output logic                 sts_all_resumeack_o,
    output logic                 sts_any_resumeack_o
);
    import rc_pkg::*;

    logic                 active_q;
    logic [NUM_HARTS-1:0] sel_mask;
    logic                 sel_in_range;
    logic [NUM_HARTS-1:0] resume_ack;
    logic [NUM_HARTS-1:0] have_reset;
    slot_cmd_t            slot_cmd [NUM_HARTS];

    // Module-active bit: power-up reset only, writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (ctl_wr_i) begin
            active_q <= ctl_active_i;
        end
    end

    assign active_o = active_q;

    rc_sel_decode #(
        .NUM_HARTS (NUM_HARTS),
        .SEL_W     (SEL_W)
    ) u_dec (
        .sel_i      (ctl_hartsel_i),
        .mask_o     (sel_mask),
        .in_range_o (sel_in_range)
    );

    // One state slot per implemented hart
    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_slot
        assign slot_cmd[g] = '{
            wr_sel:    ctl_wr_i & sel_mask[g],
            halt:      ctl_halt_i,
            resume:    ctl_resume_i,
            set_hor:   ctl_set_hor_i,
            clr_hor:   ctl_clr_hor_i,
            ack_reset: ctl_ack_reset_i
        };

        rc_hart_slot u_slot (
            .clk               (clk),
            .rst_n             (rst_n),
            .active_i          (active_q),
            .cmd_i             (slot_cmd[g]),
            .hart_halted_i     (hart_halted_i[g]),
            .hart_running_i    (hart_running_i[g]),
            .hart_reset_done_i (hart_reset_done_i[g]),
            .halt_req_o        (halt_req_o[g]),
            .resume_req_o      (resume_req_o[g]),
            .resume_ack_o      (resume_ack[g]),
            .have_reset_o      (have_reset[g])
        );
    end

    rc_status #(
        .NUM_HARTS (NUM_HARTS)
    ) u_sts (
        .clk             (clk),
        .rst_n           (rst_n),
        .sel_mask_i      (sel_mask),
        .in_range_i      (sel_in_range),
        .halted_i        (hart_halted_i),
        .unavail_i       (hart_unavail_i),
        .have_reset_i    (have_reset),
        .resume_ack_i    (resume_ack),
        .all_halted_o    (sts_all_halted_o),
        .any_halted_o    (sts_any_halted_o),
        .all_running_o   (sts_all_running_o),
        .any_running_o   (sts_any_running_o),
        .all_unavail_o   (sts_all_unavail_o),
        .any_unavail_o   (sts_any_unavail_o),
        .all_nonexist_o  (sts_all_nonexist_o),
        .any_nonexist_o  (sts_any_nonexist_o),
        .all_havereset_o (sts_all_havereset_o),
        .any_havereset_o (sts_any_havereset_o),
        .all_resumeack_o (sts_all_resumeack_o),
        .any_resumeack_o (sts_any_resumeack_o)
    );

    // R9
    active_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> (active_o == $past(ctl_active_i)));

    // R8
    sel_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_mask) && (sel_in_range == (|sel_mask)));

    // R8
    far_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_in_range |-> (sts_any_nonexist_o && !sts_any_havereset_o && !sts_any_resumeack_o));

endmodule

// File: tb/hart_runctl_bench.sv
// Bench for hart_runctl: a behavioural reference model stepped on every rising
// edge and compared with all outputs each cycle, plus directed checks.
module hart_runctl_bench;

    localparam int  NH         = 4;
    localparam int  SW         = 20;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [SW-1:0] ctl_sel = '0;
    logic          ctl_halt = 1'b0, ctl_resume = 1'b0, ctl_seth = 1'b0;
    logic          ctl_clrh = 1'b0, ctl_ack = 1'b0, ctl_act = 1'b0;
    logic [NH-1:0] h_halted = '0, h_running = '0, h_rdone = '0, h_unav = '0;
    logic          active;
    logic [NH-1:0] halt_req, resume_req;
    logic a_h, y_h, a_r, y_r, a_u, y_u, a_n, y_n, a_hr, y_hr, a_ra, y_ra;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    bit m_active;
    bit m_hr[NH], m_rr[NH], m_ack[NH], m_hor[NH], m_hrst[NH], m_pend[NH];

    always #(CLK_PERIOD/2) clk = ~clk;

    hart_runctl #(.NUM_HARTS(NH), .SEL_W(SW)) u_hart_runctl (
        .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .ctl_hartsel_i(ctl_sel),
        .ctl_halt_i(ctl_halt), .ctl_resume_i(ctl_resume), .ctl_set_hor_i(ctl_seth),
        .ctl_clr_hor_i(ctl_clrh), .ctl_ack_reset_i(ctl_ack), .ctl_active_i(ctl_act),
        .active_o(active), .hart_halted_i(h_halted), .hart_running_i(h_running),
        .hart_reset_done_i(h_rdone), .hart_unavail_i(h_unav),
        .halt_req_o(halt_req), .resume_req_o(resume_req),
        .sts_all_halted_o(a_h), .sts_any_halted_o(y_h),
        .sts_all_running_o(a_r), .sts_any_running_o(y_r),
        .sts_all_unavail_o(a_u), .sts_any_unavail_o(y_u),
        .sts_all_nonexist_o(a_n), .sts_any_nonexist_o(y_n),
        .sts_all_havereset_o(a_hr), .sts_any_havereset_o(y_hr),
        .sts_all_resumeack_o(a_ra), .sts_any_resumeack_o(y_ra)
    );

    task automatic chk(string tag, string nm, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    function automatic void model_clear(int i);
        m_hr[i] = 0; m_rr[i] = 0; m_ack[i] = 1; m_hor[i] = 0; m_hrst[i] = 0; m_pend[i] = 0;
    endfunction

    // model step on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_active = 0;
            for (int i = 0; i < NH; i++) model_clear(i);
        end else begin
            for (int i = 0; i < NH; i++) begin
                bit s, old_hor;
                if (!m_active) begin
                    model_clear(i);
                end else begin
                    s = ctl_wr && (ctl_sel == SW'(i));
                    old_hor = m_hor[i];
                    if (s) m_hr[i] = ctl_halt;
                    if (m_rr[i] && h_running[i]) begin m_rr[i] = 0; m_ack[i] = 1; end
                    if (s && ctl_resume && !ctl_halt && h_halted[i]) begin m_rr[i] = 1; m_ack[i] = 0; end
                    if (s && ctl_clrh) m_hor[i] = 0;
                    else if (s && ctl_seth) m_hor[i] = 1;
                    if (h_rdone[i]) m_hrst[i] = 1;
                    else if (s && ctl_ack) m_hrst[i] = 0;
                    if (h_rdone[i] && old_hor) m_pend[i] = 1;
                    else if (h_halted[i]) m_pend[i] = 0;
                end
            end
            if (ctl_wr) m_active = ctl_act;
        end
        started = 1;
    end

    // compare every output with the model, a quarter period after each falling edge
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (started && !done) begin
            int  s;
            bit  ex, u, h, r, hr, ra;
            chk("R9", "active", active, m_active);
            for (int i = 0; i < NH; i++) begin
                chk("R1", $sformatf("halt_req[%0d]", i), halt_req[i], m_active && (m_hr[i] || m_pend[i]));
                chk("R3", $sformatf("resume_req[%0d]", i), resume_req[i], m_active && m_rr[i]);
            end
            ex = (ctl_sel < SW'(NH));
            s  = ex ? int'(ctl_sel) : 0;
            u  = ex && h_unav[s];
            h  = ex && !h_unav[s] && h_halted[s];
            r  = ex && !h_unav[s] && !h_halted[s];
            hr = ex && m_hrst[s];
            ra = ex && m_ack[s];
            chk("R7", "all_halted", a_h, h);   chk("R7", "any_halted", y_h, h);
            chk("R7", "all_running", a_r, r);  chk("R7", "any_running", y_r, r);
            chk("R7", "all_unavail", a_u, u);  chk("R7", "any_unavail", y_u, u);
            chk("R8", "all_nonexist", a_n, !ex); chk("R8", "any_nonexist", y_n, !ex);
            chk("R5", "all_havereset", a_hr, hr); chk("R5", "any_havereset", y_hr, hr);
            chk("R4", "all_resumeack", a_ra, ra); chk("R4", "any_resumeack", y_ra, ra);
        end
    end

    // control write lasting one cycle; called at a falling edge
    task automatic wr(int sel, bit halt, bit res, bit seth, bit clrh, bit ack, bit act);
        ctl_sel = SW'(sel); ctl_halt = halt; ctl_resume = res; ctl_seth = seth;
        ctl_clrh = clrh; ctl_ack = ack; ctl_act = act; ctl_wr = 1;
        @(negedge clk);
        ctl_wr = 0; ctl_halt = 0; ctl_resume = 0; ctl_seth = 0; ctl_clrh = 0; ctl_ack = 0;
        #1;
    endtask

    task automatic pulse_rdone(int i);
        h_rdone[i] = 1'b1;
        @(negedge clk);
        h_rdone[i] = 1'b0;
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        h_running = '1;
        repeat (3) @(negedge clk);
        // R10 reset values
        #1;
        chk("R10", "reset resume_ack", y_ra, 1'b1);
        chk("R10", "reset have_reset", y_hr, 1'b0);
        chk("R10", "reset halt_req", |halt_req, 1'b0);
        chk("R10", "reset active", active, 1'b0);
        @(negedge clk);
        rst_n = 1;
        idle(1);

        // R9 activate
        wr(0, 0, 0, 0, 0, 0, 1);
        chk("R9", "active readback", active, 1'b1);
        chk("R7", "hart0 running", y_r, 1'b1);

        // R1 halt request on hart 1 only
        wr(1, 1, 0, 0, 0, 0, 1);
        chk("R1", "halt_req vector", (halt_req == 4'b0010), 1'b1);
        h_halted[1] = 1; h_running[1] = 0;
        idle(1);
        chk("R7", "hart1 halted", y_h, 1'b1);
        wr(1, 0, 0, 0, 0, 0, 1);
        chk("R1", "halt_req cleared", halt_req[1], 1'b0);

        // R3 resume a halted hart, R4 acknowledge
        wr(1, 0, 1, 0, 0, 0, 1);
        chk("R3", "resume_req raised", resume_req[1], 1'b1);
        chk("R3", "ack cleared", y_ra, 1'b0);
        h_halted[1] = 0; h_running[1] = 1;
        idle(1);
        chk("R4", "resume_req dropped", resume_req[1], 1'b0);
        chk("R4", "ack set", y_ra, 1'b1);

        // R3 resume ignored on running hart
        wr(2, 0, 1, 0, 0, 0, 1);
        ctl_sel = SW'(2);
        chk("R3", "no resume to running", resume_req[2], 1'b0);
        chk("R3", "ack kept", y_ra, 1'b1);
        // R3 halt plus resume in one write
        h_halted[2] = 1; h_running[2] = 0;
        idle(1);
        wr(2, 1, 1, 0, 0, 0, 1);
        chk("R3", "halt beats resume", resume_req[2], 1'b0);
        chk("R1", "halt taken", halt_req[2], 1'b1);
        wr(2, 0, 0, 0, 0, 0, 1);

        // R5 have-reset
        ctl_sel = SW'(3);
        pulse_rdone(3);
        chk("R5", "have_reset set", y_hr, 1'b1);
        wr(0, 0, 0, 0, 0, 1, 1);
        ctl_sel = SW'(3);
        #1;
        chk("R5", "ack other hart", y_hr, 1'b1);
        h_rdone[3] = 1;
        wr(3, 0, 0, 0, 0, 1, 1);
        h_rdone[3] = 0;
        chk("R5", "pulse beats ack", y_hr, 1'b1);
        wr(3, 0, 0, 0, 0, 1, 1);
        chk("R5", "ack clears", y_hr, 1'b0);

        // R6 and R2 halt-on-reset
        wr(0, 0, 0, 1, 0, 0, 1);
        pulse_rdone(0);
        chk("R2", "halt after reset", halt_req[0], 1'b1);
        idle(2);
        chk("R2", "held until halted", halt_req[0], 1'b1);
        h_halted[0] = 1; h_running[0] = 0;
        idle(1);
        chk("R2", "drops on halted", halt_req[0], 1'b0);
        h_halted[0] = 0; h_running[0] = 1;
        wr(0, 0, 0, 0, 1, 0, 1);
        pulse_rdone(0);
        chk("R6", "cleared hor no halt", halt_req[0], 1'b0);
        wr(0, 0, 0, 1, 1, 0, 1);
        pulse_rdone(0);
        chk("R6", "clear beats set", halt_req[0], 1'b0);

        // R7 unavailable beats halted
        h_unav[2] = 1;
        ctl_sel = SW'(2);
        #1;
        chk("R7", "unavail", y_u, 1'b1);
        chk("R7", "not halted", y_h, 1'b0);
        h_unav[2] = 0;
        idle(1);

        // R8 far indices
        ctl_sel = SW'(4);
        #1;
        chk("R8", "index 4 nonexist", y_n, 1'b1);
        ctl_sel = 20'hFFFFF;
        #1;
        chk("R8", "max index nonexist", a_n, 1'b1);
        wr(5, 1, 0, 0, 0, 0, 1);
        chk("R8", "far write no effect", |halt_req, 1'b0);

        // R9 deactivate with state present
        wr(1, 1, 0, 1, 0, 0, 1);
        pulse_rdone(1);
        wr(1, 1, 0, 0, 0, 0, 0);
        chk("R9", "inactive readback", active, 1'b0);
        chk("R9", "requests gated", |halt_req, 1'b0);
        pulse_rdone(1);
        wr(1, 1, 0, 1, 0, 0, 1);
        chk("R9", "write fields ignored", halt_req[1], 1'b0);
        ctl_sel = SW'(1);
        #1;
        chk("R9", "have_reset cleared", y_hr, 1'b0);
        chk("R9", "ack back to 1", y_ra, 1'b1);
        pulse_rdone(1);
        chk("R9", "hor was cleared", halt_req[1], 1'b0);

        idle(3);
        finish_run();
    end

endmodule